// File: doc/BRIEF.md
# Unpacked BCD Adjust Unit

This unit applies one of four decimal corrections to an accumulator pair made of a low byte (AL) and a high byte (AH). Two of the corrections tidy up a single unpacked BCD digit after a binary add or subtract. The other two convert between a two-digit number in any radix and its binary value: one packs AH:AL into a binary AL before a divide, and the other splits a binary AL into a quotient digit and a remainder digit after a multiply. The operation is chosen by its 8-bit operation code. The radix comes from the instruction's immediate byte.

The surrounding execution pipeline presents the operands, the incoming flags, the long-mode indicator and a one-cycle start strobe. It then waits for `done`. At that point the new AL, AH and flags are on the outputs, together with two fault indications: invalid opcode and divide error. The multiply-adjust split runs on an internal restoring divider that produces one quotient bit per cycle. Every other operation, and every faulting request, completes in one cycle.

Top module: `bcd_adjust_unit`

## Requirements
- R1: When `long_mode` is 1 at an accepted start, the unit raises `bad_op` together with `done`, and AL, AH and all five flags equal their input values.
- R2: Operation codes are 0x37 (adjust after add), 0x3F (adjust after subtract), 0xD5 (adjust before divide) and 0xD4 (adjust after multiply). Any other code raises `bad_op` with `done`, and AL, AH and the flags equal their inputs.
- R3: Adjust after add: if AL[3:0] > 9 or `af_in` is 1, then AL becomes AL+6, AH becomes AH+1 (wrapping mod 256), and AF=CF=1. Otherwise AH is unchanged and AF=CF=0.
- R4: Adjust after subtract uses the same condition as R3, but AL becomes AL-6 and AH becomes AH-1 (wrapping mod 256). AF=CF=1 when the condition holds, and 0 otherwise.
- R5: After add adjust and subtract adjust, AL[7:4] is 0 on either branch.
- R6: Adjust before divide gives AL = (AL + AH*radix) mod 256 and AH = 0. A radix of 0 is legal here.
- R7: Adjust after multiply with a nonzero radix gives AH = AL / radix and AL = AL mod radix, for any radix from 1 to 255.
- R8: Adjust after multiply with radix 0 raises `div_err` with `done`, and AL, AH and the flags equal their inputs.
- R9: Flags the operation does not define keep their input values. For add and subtract adjust these are SF, ZF and PF. For divide and multiply adjust these are AF and CF.
- R10: For divide and multiply adjust, SF is bit 7 of the new AL, ZF is 1 when the new AL is zero, and PF is 1 when the new AL has an even number of ones.
- R11: `done` is high for exactly one cycle per accepted start. It is high in the cycle after start for every operation and fault, except a non-faulting multiply adjust, where it is high 10 cycles after start. The fault outputs are high only together with `done`.
- R12: A start while a multiply adjust is in progress is ignored. It does not change the result or the latency, and it produces no extra `done`.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when the unit is idle |
| op_code | input | 8 | Operation code (R2) |
| al_in | input | 8 | Incoming low accumulator byte |
| ah_in | input | 8 | Incoming high accumulator byte |
| radix | input | 8 | Number base from the immediate byte |
| long_mode | input | 1 | 1 traps every operation as invalid |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary carry flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| pf_in | input | 1 | Incoming parity flag |
| al_out | output | 8 | Result low byte |
| ah_out | output | 8 | Result high byte |
| cf_out | output | 1 | Result carry flag |
| af_out | output | 1 | Result auxiliary carry flag |
| sf_out | output | 1 | Result sign flag |
| zf_out | output | 1 | Result zero flag |
| pf_out | output | 1 | Result parity flag |
| div_err | output | 1 | Divide-error fault, valid with done |
| bad_op | output | 1 | Invalid-opcode fault, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches several properties on every cycle:
- the long-mode trap, the unknown-code trap and the radix-zero trap one cycle after they are requested;
- the cleared upper nibble after add and subtract adjust, and the zero AH after divide adjust;
- a remainder below the radix after multiply adjust;
- the SF/ZF/PF relation to the new AL;
- the rule that `done` never appears and the results never move while the divider runs.

Only the bench's scenarios can show the following, because they need an independent model of the arithmetic:
- the exact AL/AH values, including AH wrap-around on add and subtract;
- the truncation of an oversized divide-adjust sum;
- the values of flags that are held;
- the 10-cycle latency;
- the fact that a start arriving mid-divide leaves no trace.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

   localparam logic [7:0] OPC_ADD_ADJ = 8'h37;
   localparam logic [7:0] OPC_SUB_ADJ = 8'h3F;
   localparam logic [7:0] OPC_PRE_DIV = 8'hD5;
   localparam logic [7:0] OPC_PST_MUL = 8'hD4;

   typedef enum logic [2:0] {
      K_ADD,
      K_SUB,
      K_PRE_DIV,
      K_PST_MUL,
      K_BAD
   } adj_kind_e;

   typedef enum logic {
      ST_IDLE,
      ST_DIV
   } adj_state_e;

   typedef struct packed {
      logic sf;
      logic zf;
      logic af;
      logic pf;
      logic cf;
   } adj_flags_t;

   function automatic adj_kind_e decode_op(input logic [7:0] opc);
      case (opc)
         OPC_ADD_ADJ: return K_ADD;
         OPC_SUB_ADJ: return K_SUB;
         OPC_PRE_DIV: return K_PRE_DIV;
         OPC_PST_MUL: return K_PST_MUL;
         default:     return K_BAD;
      endcase
   endfunction

endpackage

// File: rtl/bcd_adj_fast.sv
// Single-cycle corrections: add adjust, subtract adjust, pre-divide pack.
module bcd_adj_fast
   import bcd_adj_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit SHIFT_ADD_MUL = 1'b1
) (
   input  adj_kind_e          kind,
   input  logic [DATA_W-1:0]  al,
   input  logic [DATA_W-1:0]  ah,
   input  logic [DATA_W-1:0]  radix,
   input  adj_flags_t         fl_i,
   output logic [DATA_W-1:0]  al_o,
   output logic [DATA_W-1:0]  ah_o,
   output adj_flags_t         fl_o
);
   localparam int               NIB  = 4;
   localparam logic [NIB-1:0]   NINE = NIB'(9);
   localparam logic [DATA_W-1:0] SIX = DATA_W'(6);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] prod;

   // AH * radix, truncated to DATA_W bits
   generate
      if (SHIFT_ADD_MUL) begin : g_shift_add
         logic [DATA_W-1:0] acc [DATA_W+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_row
            assign acc[i+1] = acc[i] + (radix[i] ? (ah << i) : '0);
         end
         assign prod = acc[DATA_W];
      end else begin : g_direct
         assign prod = ah * radix;
      end
   endgenerate

   logic              lo_hit;
   logic [DATA_W-1:0] al_t;

   always_comb begin
      lo_hit = (al[NIB-1:0] > NINE) || fl_i.af;
      al_t   = al;
      al_o   = al;
      ah_o   = ah;
      fl_o   = fl_i;
      case (kind)
         K_ADD: begin
            al_t    = lo_hit ? al + SIX : al;
            ah_o    = lo_hit ? ah + ONE : ah;
            fl_o.af = lo_hit;
            fl_o.cf = lo_hit;
            al_o    = {{(DATA_W-NIB){1'b0}}, al_t[NIB-1:0]};
         end
         K_SUB: begin
            al_t    = lo_hit ? al - SIX : al;
            ah_o    = lo_hit ? ah - ONE : ah;
            fl_o.af = lo_hit;
            fl_o.cf = lo_hit;
            al_o    = {{(DATA_W-NIB){1'b0}}, al_t[NIB-1:0]};
         end
         K_PRE_DIV: begin
            al_o    = al + prod;
            ah_o    = '0;
            fl_o.sf = al_o[DATA_W-1];
            fl_o.zf = (al_o == '0);
            fl_o.pf = ~^al_o;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bcd_adj_div.sv
// Restoring divider, one quotient bit per cycle.
module bcd_adj_div #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem,
   output logic         valid
);
   localparam int          CNT_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   logic [W-1:0]     q_r, r_r;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [W:0]       r_sh, diff;
   logic             fits;

   assign r_sh = {r_r, q_r[W-1]};
   assign diff = r_sh - {1'b0, divisor};
   assign fits = (r_sh >= {1'b0, divisor});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r   <= '0;
         r_r   <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (load) begin
            q_r <= dividend;
            r_r <= '0;
            cnt <= '0;
            run <= 1'b1;
         end else if (run) begin
            r_r <= fits ? diff[W-1:0] : r_sh[W-1:0];
            q_r <= {q_r[W-2:0], fits};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
               run   <= 1'b0;
               valid <= 1'b1;
            end
         end
      end
   end

   assign quot = q_r;
   assign rem  = r_r;

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
   import bcd_adj_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit SHIFT_ADD_MUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        op_code,
   input  logic [DATA_W-1:0] al_in,
   input  logic [DATA_W-1:0] ah_in,
   input  logic [DATA_W-1:0] radix,
   input  logic              long_mode,
   input  logic              cf_in,
   input  logic              af_in,
   input  logic              sf_in,
   input  logic              zf_in,
   input  logic              pf_in,
   output logic [DATA_W-1:0] al_out,
   output logic [DATA_W-1:0] ah_out,
   output logic              cf_out,
   output logic              af_out,
   output logic              sf_out,
   output logic              zf_out,
   output logic              pf_out,
   output logic              div_err,
   output logic              bad_op,
   output logic              done
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("bcd_adjust_unit: DATA_W must be at least 8");
      end
   endgenerate

   adj_state_e        state;
   logic              busy, accept, ud_now, de_now, div_go;
   adj_kind_e         kind;
   adj_flags_t        fl_in, fl_fast, fl_div;
   logic [DATA_W-1:0] al_fast, ah_fast, div_q, div_r;
   logic              div_valid;
   logic [7:0]        op_q;
   logic [DATA_W-1:0] radix_q;
   logic              af_q, cf_q;

   assign busy   = (state == ST_DIV);
   assign kind   = decode_op(op_code);
   assign accept = start && !busy;
   assign ud_now = long_mode || (kind == K_BAD);
   assign de_now = !ud_now && (kind == K_PST_MUL) && (radix == '0);
   assign div_go = accept && (kind == K_PST_MUL) && !ud_now && !de_now;
   assign fl_in  = '{sf: sf_in, zf: zf_in, af: af_in, pf: pf_in, cf: cf_in};

   bcd_adj_fast #(.DATA_W(DATA_W), .SHIFT_ADD_MUL(SHIFT_ADD_MUL)) u_fast (
      .kind (kind),
      .al   (al_in),
      .ah   (ah_in),
      .radix(radix),
      .fl_i (fl_in),
      .al_o (al_fast),
      .ah_o (ah_fast),
      .fl_o (fl_fast)
   );

   // divisor is held in radix_q while the divider runs
   bcd_adj_div #(.W(DATA_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (div_go),
      .dividend(al_in),
      .divisor (radix_q),
      .quot    (div_q),
      .rem     (div_r),
      .valid   (div_valid)
   );

   always_comb begin
      fl_div    = '0;
      fl_div.sf = div_r[DATA_W-1];
      fl_div.zf = (div_r == '0);
      fl_div.pf = ~^div_r;
      fl_div.af = af_q;
      fl_div.cf = cf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= '0;
         radix_q <= '0;
         af_q    <= 1'b0;
         cf_q    <= 1'b0;
         al_out  <= '0;
         ah_out  <= '0;
         {sf_out, zf_out, af_out, pf_out, cf_out} <= '0;
         div_err <= 1'b0;
         bad_op  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done    <= 1'b0;
         div_err <= 1'b0;
         bad_op  <= 1'b0;
         if (accept) begin
            op_q    <= op_code;
            radix_q <= radix;
            af_q    <= af_in;
            cf_q    <= cf_in;
            if (div_go) begin
               state <= ST_DIV;
            end else begin
               done    <= 1'b1;
               bad_op  <= ud_now;
               div_err <= de_now;
               if (ud_now || de_now) begin
                  al_out <= al_in;
                  ah_out <= ah_in;
                  {sf_out, zf_out, af_out, pf_out, cf_out} <= fl_in;
               end else begin
                  al_out <= al_fast;
                  ah_out <= ah_fast;
                  {sf_out, zf_out, af_out, pf_out, cf_out} <= fl_fast;
               end
            end
         end else if (busy && div_valid) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            al_out <= div_r;
            ah_out <= div_q;
            {sf_out, zf_out, af_out, pf_out, cf_out} <= fl_div;
         end
      end
   end

endmodule

// File: rtl/bcd_adj_chk.sv
module bcd_adj_chk
   import bcd_adj_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              long_mode,
   input logic [7:0]        op_code,
   input logic [DATA_W-1:0] radix,
   input logic [DATA_W-1:0] al_in,
   input logic [DATA_W-1:0] ah_in,
   input logic              busy,
   input logic [7:0]        op_q,
   input logic [DATA_W-1:0] radix_q,
   input logic              done,
   input logic              bad_op,
   input logic              div_err,
   input logic [DATA_W-1:0] al_out,
   input logic [DATA_W-1:0] ah_out,
   input logic              sf_out,
   input logic              zf_out,
   input logic              pf_out
);
   logic clean;
   assign clean = done && !bad_op && !div_err;

   p_longmode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && long_mode) |=>
      (done && bad_op && al_out == $past(al_in) && ah_out == $past(ah_in)));

   p_unknown_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && decode_op(op_code) == K_BAD) |=> (done && bad_op));

   p_nibble_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clean && (op_q == OPC_ADD_ADJ || op_q == OPC_SUB_ADJ)) |->
      (al_out[DATA_W-1:4] == '0));

   p_ah_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clean && op_q == OPC_PRE_DIV) |-> (ah_out == '0));

   p_rem_below_radix_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clean && op_q == OPC_PST_MUL) |-> (al_out < radix_q));

   p_radix_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !long_mode && op_code == OPC_PST_MUL && radix == '0) |=>
      (done && div_err && !bad_op));

   p_szp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clean && (op_q == OPC_PRE_DIV || op_q == OPC_PST_MUL)) |->
      (zf_out == (al_out == '0) && sf_out == al_out[DATA_W-1] && pf_out == ~^al_out));

   p_fault_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_op || div_err) |-> done);

   p_no_done_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   p_hold_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(al_out) && $stable(ah_out)));

endmodule

bind bcd_adjust_unit bcd_adj_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .long_mode(long_mode),
   .op_code  (op_code),
   .radix    (radix),
   .al_in    (al_in),
   .ah_in    (ah_in),
   .busy     (busy),
   .op_q     (op_q),
   .radix_q  (radix_q),
   .done     (done),
   .bad_op   (bad_op),
   .div_err  (div_err),
   .al_out   (al_out),
   .ah_out   (ah_out),
   .sf_out   (sf_out),
   .zf_out   (zf_out),
   .pf_out   (pf_out)
);

// File: tb/sim_bcd_adjust_unit.sv
module sim_bcd_adjust_unit;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [7:0] op_code, al_in, ah_in, radix;
   logic       long_mode, cf_in, af_in, sf_in, zf_in, pf_in;
   logic [7:0] al_out, ah_out;
   logic       cf_out, af_out, sf_out, zf_out, pf_out, div_err, bad_op, done;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   bcd_adjust_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .al_in(al_in), .ah_in(ah_in), .radix(radix), .long_mode(long_mode),
      .cf_in(cf_in), .af_in(af_in), .sf_in(sf_in), .zf_in(zf_in), .pf_in(pf_in),
      .al_out(al_out), .ah_out(ah_out), .cf_out(cf_out), .af_out(af_out),
      .sf_out(sf_out), .zf_out(zf_out), .pf_out(pf_out),
      .div_err(div_err), .bad_op(bad_op), .done(done)
   );

   typedef struct {
      logic [7:0] al, ah;
      logic [4:0] fl;   // {sf, zf, af, pf, cf}
      logic       de, ud;
      int         lat;
   } exp_t;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [7:0] op, al, ah, rdx, input logic lm,
                                  input logic [4:0] fl);
      exp_t e;
      logic hit;
      int   sum;
      e.al = al; e.ah = ah; e.fl = fl; e.de = 1'b0; e.ud = 1'b0; e.lat = 1;
      hit = (al[3:0] > 4'd9) || fl[2];
      if (lm || !(op == 8'h37 || op == 8'h3F || op == 8'hD5 || op == 8'hD4)) begin
         e.ud = 1'b1;
         return e;
      end
      case (op)
         8'h37: begin
            e.al = hit ? ((al + 8'd6) & 8'h0F) : (al & 8'h0F);
            e.ah = hit ? ah + 8'd1 : ah;
            e.fl[2] = hit; e.fl[0] = hit;
         end
         8'h3F: begin
            e.al = hit ? ((al - 8'd6) & 8'h0F) : (al & 8'h0F);
            e.ah = hit ? ah - 8'd1 : ah;
            e.fl[2] = hit; e.fl[0] = hit;
         end
         8'hD5: begin
            sum  = int'(al) + int'(ah) * int'(rdx);
            e.al = sum[7:0];
            e.ah = 8'h00;
         end
         default: begin
            if (rdx == 8'h00) begin
               e.de = 1'b1;
               return e;
            end
            e.ah  = al / rdx;
            e.al  = al % rdx;
            e.lat = 10;
         end
      endcase
      if (op == 8'hD5 || op == 8'hD4) begin
         e.fl[4] = e.al[7];
         e.fl[3] = (e.al == 8'h00);
         e.fl[1] = ~^e.al;
      end
      return e;
   endfunction

   task automatic run_op(input logic [7:0] op, al, ah, rdx, input logic lm,
                         input logic [4:0] fl);
      exp_t  e;
      int    lat;
      string tv, tsz, tac;
      e = model(op, al, ah, rdx, lm, fl);
      @(negedge clk);
      op_code = op; al_in = al; ah_in = ah; radix = rdx; long_mode = lm;
      {sf_in, zf_in, af_in, pf_in, cf_in} = fl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 30) begin
         @(negedge clk);
         lat++;
      end
      case (op)
         8'h37:   begin tv = "R3"; tsz = "R9";  tac = "R3"; end
         8'h3F:   begin tv = "R4"; tsz = "R9";  tac = "R4"; end
         8'hD5:   begin tv = "R6"; tsz = "R10"; tac = "R9"; end
         default: begin tv = "R7"; tsz = "R10"; tac = "R9"; end
      endcase
      if (e.ud) begin
         tv = lm ? "R1" : "R2"; tsz = tv; tac = tv;
      end else if (e.de) begin
         tv = "R8"; tsz = "R8"; tac = "R8";
      end
      chk("R11", "latency", lat, e.lat);
      chk(lm ? "R1" : "R2", "bad_op", int'(bad_op), int'(e.ud));
      chk("R8", "div_err", int'(div_err), int'(e.de));
      chk(tv, "al", int'(al_out), int'(e.al));
      chk(tv, "ah", int'(ah_out), int'(e.ah));
      chk(tsz, "sf/zf/pf", int'({sf_out, zf_out, pf_out}),
          int'({e.fl[4], e.fl[3], e.fl[1]}));
      chk(tac, "af/cf", int'({af_out, cf_out}), int'({e.fl[2], e.fl[0]}));
      if (!e.ud && (op == 8'h37 || op == 8'h3F))
         chk("R5", "al high nibble", int'(al_out[7:4]), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'hBCD0_5EED));
      rst_n = 1'b0; start = 1'b0; op_code = '0; al_in = '0; ah_in = '0; radix = '0;
      long_mode = 1'b0; {sf_in, zf_in, af_in, pf_in, cf_in} = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13", "al/ah", int'({al_out, ah_out}), 0);
      chk("R13", "flags", int'({sf_out, zf_out, af_out, pf_out, cf_out}), 0);
      chk("R13", "done/faults", int'({done, bad_op, div_err}), 0);

      // directed corners
      run_op(8'h37, 8'h0F, 8'h02, 8'h0A, 1'b0, 5'b10010); // R3 nibble > 9
      run_op(8'h37, 8'h08, 8'h03, 8'h0A, 1'b0, 5'b00100); // R3 af_in set
      run_op(8'h37, 8'h39, 8'h04, 8'h0A, 1'b0, 5'b01001); // R5 no adjust, top cleared
      run_op(8'h37, 8'h0C, 8'hFF, 8'h0A, 1'b0, 5'b00000); // R3 AH wraps
      run_op(8'h3F, 8'hFA, 8'h05, 8'h0A, 1'b0, 5'b10000); // R4 borrow
      run_op(8'h3F, 8'h0B, 8'h00, 8'h0A, 1'b0, 5'b00000); // R4 AH wraps to FF
      run_op(8'h3F, 8'h47, 8'h05, 8'h0A, 1'b0, 5'b01011); // R4 no borrow
      run_op(8'hD5, 8'h05, 8'h07, 8'h0A, 1'b0, 5'b00101); // R6 75 decimal
      run_op(8'hD5, 8'h09, 8'h09, 8'h20, 1'b0, 5'b00000); // R6 truncation
      run_op(8'hD5, 8'h33, 8'h44, 8'h00, 1'b0, 5'b00000); // R6 radix zero legal
      run_op(8'hD4, 8'h4B, 8'h00, 8'h0A, 1'b0, 5'b00101); // R7 decimal
      run_op(8'hD4, 8'h3F, 8'h11, 8'h08, 1'b0, 5'b00000); // R7 octal
      run_op(8'hD4, 8'h8F, 8'h11, 8'h0C, 1'b0, 5'b00000); // R7 base 12
      run_op(8'hD4, 8'hFF, 8'h00, 8'h01, 1'b0, 5'b00000); // R7 radix 1
      run_op(8'hD4, 8'hFE, 8'h00, 8'hFF, 1'b0, 5'b00000); // R7 radix 255
      run_op(8'hD4, 8'h42, 8'h13, 8'h00, 1'b0, 5'b10101); // R8 radix zero
      run_op(8'h37, 8'h0F, 8'h02, 8'h0A, 1'b1, 5'b01010); // R1
      run_op(8'h3F, 8'h0F, 8'h02, 8'h0A, 1'b1, 5'b00001); // R1
      run_op(8'hD5, 8'h05, 8'h07, 8'h0A, 1'b1, 5'b11111); // R1
      run_op(8'hD4, 8'h4B, 8'h07, 8'h00, 1'b1, 5'b00100); // R1 beats R8
      run_op(8'h00, 8'h12, 8'h34, 8'h0A, 1'b0, 5'b10101); // R2 unknown code
      run_op(8'hD6, 8'h12, 8'h34, 8'h0A, 1'b0, 5'b01010); // R2 unknown code

      // R12: start during a running multiply adjust is ignored
      begin
         int lat;
         @(negedge clk);
         op_code = 8'hD4; al_in = 8'h4B; ah_in = 8'h99; radix = 8'h0A; long_mode = 1'b0;
         {sf_in, zf_in, af_in, pf_in, cf_in} = 5'b00000;
         start = 1'b1;
         @(negedge clk); start = 1'b0; lat = 1;
         @(negedge clk); lat++;
         op_code = 8'h37; al_in = 8'h0F; ah_in = 8'h22; start = 1'b1;
         @(negedge clk); lat++; start = 1'b0;
         while (!done && lat < 30) begin
            @(negedge clk);
            lat++;
         end
         chk("R12", "latency with ignored start", lat, 10);
         chk("R12", "al", int'(al_out), 5);
         chk("R12", "ah", int'(ah_out), 7);
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R12", "extra done", int'(done), 0);
            chk("R12", "al held", int'(al_out), 5);
         end
      end

      // constrained random
      for (int n = 0; n < 400; n++) begin
         logic [7:0] op, rdx;
         logic       lm;
         case ($urandom % 9)
            0, 1:    op = 8'h37;
            2, 3:    op = 8'h3F;
            4, 5:    op = 8'hD5;
            6, 7:    op = 8'hD4;
            default: op = 8'($urandom);
         endcase
         case ($urandom % 8)
            0, 1:    rdx = 8'h0A;
            2:       rdx = 8'h08;
            3:       rdx = 8'h0C;
            4:       rdx = 8'h00;
            default: rdx = 8'($urandom);
         endcase
         lm = (($urandom % 10) == 0);
         run_op(op, 8'($urandom), 8'($urandom), rdx, lm, 5'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule